// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Condition Codes

This block is the combinational datapath core of a small 8-bit accumulator processor. It takes two 8-bit operands, a carry input, the current condition-code byte and a 5-bit operation code. From these it returns the 8-bit result, the next condition-code byte and a write-back request. The surrounding core fetches operands, decodes instructions and owns the registers. This unit only computes. It holds no state, and every output settles in the same cycle as its inputs.

Each operation follows its own flag rule. Addition alone updates the half-carry flag. Increment and decrement leave the carry flag as it was. Logic operations clear overflow. Shifts and rotates derive overflow from the new sign and the new carry. A decimal-adjust operation uses the half-carry and carry flags to correct a packed BCD sum. Compare, bit test and test update the flags but do not request a write-back of the result.

Top module: `alu8_core`

## Requirements
- R1: The flag byte has this layout: half-carry bit 5, negative bit 3, zero bit 2, overflow bit 1 and carry bit 0. Bits 7, 6 and 4 of `ccr_in` reach `ccr_out` unchanged for every operation code. Half-carry also passes unchanged for every operation except codes 0 and 1.
- R2: Add (code 0) returns a+b and add-with-carry (code 1) returns a+b+carry_in, both modulo 256. Half-carry is the carry out of bit 3. Carry is the carry out of bit 7. Overflow is set when both operands have the same sign and the result has the other sign. N is result bit 7. Z is set when the result is zero.
- R3: Subtract (code 2) returns a-b. Subtract-with-borrow (code 3) returns a-b-carry_in. Compare (code 4) computes a-b. Carry is set when a borrow occurs. Overflow is set when the operands differ in sign and the result sign differs from a. N and Z come from the result. Half-carry is kept.
- R4: AND (5), OR (6), XOR (7) and bit test (8, which computes a AND b) work on a and b. Pass (9) returns b. All five set N and Z from the result, force V to 0 and keep C.
- R5: Clear (code 10) returns 0 and gives N=0, Z=1, V=0, C=0.
- R6: Complement (code 11) returns the bitwise inverse of a, with V=0 and C=1.
- R7: Negate (code 12) returns 0-a. C is set when a is nonzero. V is set only when a is 0x80.
- R8: Increment (13) and decrement (14) return a+1 and a-1 modulo 256. They set N and Z from the result and leave C unchanged. V is set for increment only when a is 0x7F, and for decrement only when a is 0x80.
- R9: Shift left (16) moves 0 into bit 0. Arithmetic shift right (17) keeps bit 7. Logical shift right (18) moves 0 into bit 7, so N is always 0. In each case the bit shifted out goes to C, and V equals N XOR C after the operation.
- R10: Rotate left (19) and rotate right (20) form a 9-bit ring of carry_in and a. Rotate left enters carry_in at bit 0 and sends bit 7 to C. Rotate right enters carry_in at bit 7 and sends bit 0 to C. V equals N XOR C.
- R11: Test (code 15) returns a, sets N and Z from a and clears both V and C.
- R12: Decimal adjust (code 21) adds 0x06 when the low nibble of a exceeds 9 or the incoming H is set. It adds 0x60 when the incoming C is set, when the high nibble exceeds 9, or when the high nibble is at least 9 and the low nibble exceeds 9. C becomes the incoming C OR the high correction. V is 0, and N and Z come from the result.
- R13: `wr_en` is 0 for compare, bit test and test, and 1 for every other defined code (0–21). Codes 22–31 are undefined: they return a, leave `ccr_out` equal to `ccr_in` and drive `wr_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (0–21 defined, see requirements) |
| opnd_a | input | 8 | First operand; sole operand of unary operations |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry for add/subtract with carry and for rotates |
| ccr_in | input | 8 | Current condition-code byte |
| result | output | 8 | Operation result |
| ccr_out | output | 8 | Next condition-code byte |
| wr_en | output | 1 | Requests write-back of `result` |

## Verification
The unit has no state, so any fault in an internal term shows at the ports at once, in the same cycle as the stimulus. A wrong half-carry or nibble term shows up as a wrong decimal-adjust result only when H or a nibble boundary is involved. A carry that leaks into increment or decrement shows up only when the incoming C differs from the value the adder would produce. For this reason the stimulus sweeps the flag byte together with the operands. Add-with-carry and subtract-with-borrow are checked over every operand pair and both carry values. All other codes are checked over every first operand against a spread of second operands, including the 0x7F and 0x80 edges.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 5;
    localparam int NIB_W  = DATA_W / 2;

    // flag positions inside the condition-code byte
    localparam int CC_H = 5;
    localparam int CC_N = 3;
    localparam int CC_Z = 2;
    localparam int CC_V = 1;
    localparam int CC_C = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_ORR = 5'd6,  OP_EOR = 5'd7,
        OP_BIT = 5'd8,  OP_PAS = 5'd9,  OP_CLR = 5'd10, OP_COM = 5'd11,
        OP_NEG = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_TST = 5'd15,
        OP_ASL = 5'd16, OP_ASR = 5'd17, OP_LSR = 5'd18, OP_ROL = 5'd19,
        OP_ROR = 5'd20, OP_DAA = 5'd21
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_ASL, SH_ASR, SH_LSR, SH_ROL, SH_ROR
    } shift_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         half,
    output logic         ovf,
    output logic         cout
);
    localparam int NW = W / 2;

    logic [W:0]  full;
    logic [NW:0] nib;

    always_comb begin
        if (sub) full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
        else     full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        nib  = {1'b0, x[NW-1:0]} + {1'b0, y[NW-1:0]} + {{NW{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
        half = nib[NW];
        if (sub) ovf = (x[W-1] != y[W-1]) && (full[W-1] != x[W-1]);
        else     ovf = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
    end

    // borrow flag must agree with a magnitude comparison of the inputs
    always_comb begin
        if (!$isunknown({x, y, cin, sub}) && sub) begin
            p_borrow_r3: assert (cout == ({1'b0, x} < ({1'b0, y} + {{W{1'b0}}, cin})));
        end
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  shift_e       kind,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    always_comb begin
        unique case (kind)
            SH_ASL: begin res = {a[W-2:0], 1'b0};  cout = a[W-1]; end
            SH_ASR: begin res = {a[W-1], a[W-1:1]}; cout = a[0];  end
            SH_LSR: begin res = {1'b0, a[W-1:1]};  cout = a[0];   end
            SH_ROL: begin res = {a[W-2:0], cin};   cout = a[W-1]; end
            SH_ROR: begin res = {cin, a[W-1:1]};   cout = a[0];   end
            default: begin res = a; cout = cin; end
        endcase
    end

    // the ring of carry and operand loses no bit
    always_comb begin
        if (!$isunknown({kind, a, cin}) && (kind == SH_ROL || kind == SH_ROR)) begin
            p_ring_count_r10: assert ($countones({cout, res}) == $countones({cin, a}));
        end
    end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic              h_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);
    logic [NIB_W-1:0] lo, hi;
    logic             lo_fix, hi_fix;

    always_comb begin
        lo     = a[NIB_W-1:0];
        hi     = a[DATA_W-1:NIB_W];
        lo_fix = (lo > 4'd9) || h_in;
        hi_fix = c_in || (hi > 4'd9) || ((hi >= 4'd9) && (lo > 4'd9));
        res    = a + {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
        c_out  = c_in | hi_fix;
    end

    // an incoming carry is never dropped
    always_comb begin
        if (!$isunknown({a, h_in, c_in}) && c_in) begin
            p_carry_sticky_r12: assert (c_out);
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] ccr_in,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] ccr_out,
    output logic              wr_en
);
    alu_op_e op;
    assign op = alu_op_e'(op_sel);

    // shared adder / subtractor
    logic [DATA_W-1:0] as_x, as_y, as_sum;
    logic              as_cin, as_sub, as_h, as_v, as_c;

    assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_NEG);
    assign as_x   = (op == OP_NEG) ? '0 : opnd_a;
    assign as_y   = (op == OP_NEG) ? opnd_a : opnd_b;
    assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .half(as_h), .ovf(as_v), .cout(as_c)
    );

    // shifter
    shift_e            sh_kind;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;

    always_comb begin
        case (op)
            OP_ASR:  sh_kind = SH_ASR;
            OP_LSR:  sh_kind = SH_LSR;
            OP_ROL:  sh_kind = SH_ROL;
            OP_ROR:  sh_kind = SH_ROR;
            default: sh_kind = SH_ASL;
        endcase
    end

    alu8_shift #(.W(DATA_W)) u_shift (
        .kind(sh_kind), .a(opnd_a), .cin(carry_in), .res(sh_res), .cout(sh_c)
    );

    // decimal adjust
    logic [DATA_W-1:0] da_res;
    logic              da_c;

    alu8_decadj u_decadj (
        .a(opnd_a), .h_in(ccr_in[CC_H]), .c_in(ccr_in[CC_C]), .res(da_res), .c_out(da_c)
    );

    // operation select and flag rules
    logic fh, fv, fc, fn, fz, upd_nz;

    always_comb begin
        result = opnd_a;
        fh     = ccr_in[CC_H];
        fv     = ccr_in[CC_V];
        fc     = ccr_in[CC_C];
        upd_nz = 1'b1;
        wr_en  = 1'b1;
        unique case (op)
            OP_ADD, OP_ADC: begin
                result = as_sum; fh = as_h; fv = as_v; fc = as_c;
            end
            OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
                result = as_sum; fv = as_v; fc = as_c;
                wr_en  = (op != OP_CMP);
            end
            OP_AND: begin result = opnd_a & opnd_b; fv = 1'b0; end
            OP_ORR: begin result = opnd_a | opnd_b; fv = 1'b0; end
            OP_EOR: begin result = opnd_a ^ opnd_b; fv = 1'b0; end
            OP_BIT: begin result = opnd_a & opnd_b; fv = 1'b0; wr_en = 1'b0; end
            OP_PAS: begin result = opnd_b;          fv = 1'b0; end
            OP_CLR: begin result = '0; fv = 1'b0; fc = 1'b0; end
            OP_COM: begin result = ~opnd_a; fv = 1'b0; fc = 1'b1; end
            OP_INC: begin
                result = opnd_a + 8'd1;
                fv     = (opnd_a == 8'h7F);
            end
            OP_DEC: begin
                result = opnd_a - 8'd1;
                fv     = (opnd_a == 8'h80);
            end
            OP_TST: begin fv = 1'b0; fc = 1'b0; wr_en = 1'b0; end
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
                result = sh_res; fc = sh_c;
                fv     = sh_res[DATA_W-1] ^ sh_c;
            end
            OP_DAA: begin result = da_res; fc = da_c; fv = 1'b0; end
            default: begin upd_nz = 1'b0; wr_en = 1'b0; end
        endcase
        fn = upd_nz ? result[DATA_W-1] : ccr_in[CC_N];
        fz = upd_nz ? (result == '0)    : ccr_in[CC_Z];
    end

    always_comb begin
        ccr_out       = ccr_in;
        ccr_out[CC_H] = fh;
        ccr_out[CC_N] = fn;
        ccr_out[CC_Z] = fz;
        ccr_out[CC_V] = fv;
        ccr_out[CC_C] = fc;
    end

    // port-level checks beside the flag logic
    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b, carry_in, ccr_in})) begin
            p_upper_kept_r1: assert (ccr_out[7:6] == ccr_in[7:6] && ccr_out[4] == ccr_in[4]);
            if (op == OP_INC || op == OP_DEC)
                p_inc_carry_kept_r8: assert (ccr_out[CC_C] == ccr_in[CC_C]);
            if (op == OP_CLR)
                p_clr_flags_r5: assert (result == '0 && ccr_out[3:0] == 4'b0100);
            if (op == OP_LSR)
                p_lsr_positive_r9: assert (!ccr_out[CC_N]);
            if (op == OP_ADD)
                p_add_zero_r2: assert (ccr_out[CC_Z] == ((opnd_a + opnd_b) == 8'h00));
            if (op == OP_CMP || op == OP_BIT || op == OP_TST)
                p_no_write_r13: assert (!wr_en);
        end
    end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    import alu8_pkg::*;

    logic       clk = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0, ccr_in = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result, ccr_out;
    logic       wr_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alu8_core dut (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .ccr_in(ccr_in), .result(result), .ccr_out(ccr_out), .wr_en(wr_en)
    );

    function automatic string tag_of(input int op);
        case (op)
            0, 1:        return "R2";
            2, 3, 4:     return "R3";
            5, 6, 7, 8, 9: return "R4";
            10:          return "R5";
            11:          return "R6";
            12:          return "R7";
            13, 14:      return "R8";
            15:          return "R11";
            16, 17, 18:  return "R9";
            19, 20:      return "R10";
            21:          return "R12";
            default:     return "R13";
        endcase
    endfunction

    // behavioural reference built from the requirement text
    function automatic void ref_model(input int op, input int a, input int b, input int ci,
                                      input int ccr, output int r, output int cc, output int w);
        int h, n, z, v, c, s, nz, lo, hi, k;
        h = (ccr >> 5) & 1; v = (ccr >> 1) & 1; c = ccr & 1;
        nz = 1; r = a; w = 1;
        case (op)
            0, 1: begin
                k = (op == 1) ? ci : 0;
                s = a + b + k; r = s & 255; c = (s > 255) ? 1 : 0;
                h = (((a & 15) + (b & 15) + k) > 15) ? 1 : 0;
                v = (((a ^ r) & (b ^ r) & 128) != 0) ? 1 : 0;
            end
            2, 3, 4: begin
                k = (op == 3) ? ci : 0;
                s = a - b - k; r = s & 255; c = (s < 0) ? 1 : 0;
                v = (((a ^ b) & (a ^ r) & 128) != 0) ? 1 : 0;
                w = (op != 4) ? 1 : 0;
            end
            5:  begin r = a & b; v = 0; end
            6:  begin r = a | b; v = 0; end
            7:  begin r = a ^ b; v = 0; end
            8:  begin r = a & b; v = 0; w = 0; end
            9:  begin r = b; v = 0; end
            10: begin r = 0; v = 0; c = 0; end
            11: begin r = (~a) & 255; v = 0; c = 1; end
            12: begin r = (256 - a) & 255; c = (a != 0) ? 1 : 0; v = (a == 128) ? 1 : 0; end
            13: begin r = (a + 1) & 255; v = (a == 127) ? 1 : 0; end
            14: begin r = (a + 255) & 255; v = (a == 128) ? 1 : 0; end
            15: begin r = a; v = 0; c = 0; w = 0; end
            16: begin c = (a >> 7) & 1; r = (a << 1) & 255; end
            17: begin c = a & 1; r = (a >> 1) | (a & 128); end
            18: begin c = a & 1; r = a >> 1; end
            19: begin c = (a >> 7) & 1; r = ((a << 1) | ci) & 255; end
            20: begin c = a & 1; r = (a >> 1) | (ci << 7); end
            21: begin
                lo = ((a & 15) > 9 || h == 1) ? 1 : 0;
                hi = (c == 1 || (a >> 4) > 9 || ((a >> 4) >= 9 && (a & 15) > 9)) ? 1 : 0;
                r = (a + (lo ? 6 : 0) + (hi ? 96 : 0)) & 255;
                c = c | hi; v = 0;
            end
            default: begin nz = 0; w = 0; end
        endcase
        if (op >= 16 && op <= 20) v = ((r >> 7) & 1) ^ c;
        n = nz ? ((r >> 7) & 1) : ((ccr >> 3) & 1);
        z = nz ? ((r == 0) ? 1 : 0) : ((ccr >> 2) & 1);
        cc = (ccr & 8'hD0) | (h << 5) | (n << 3) | (z << 2) | (v << 1) | c;
    endfunction

    task automatic run_vec(input int op, input int a, input int b, input int ci,
                           input int ccr, input string tag);
        int er, ec, ew;
        op_sel = 5'(op); opnd_a = 8'(a); opnd_b = 8'(b);
        carry_in = 1'(ci); ccr_in = 8'(ccr);
        #1;
        ref_model(op, a, b, ci, ccr, er, ec, ew);
        checks++;
        if (result !== 8'(er) || ccr_out !== 8'(ec)) begin
            failures++;
            $display("FAIL %s op=%0d a=%02h b=%02h ci=%0d ccr=%02h: got res=%02h ccr=%02h, expected res=%02h ccr=%02h",
                     tag, op, a, b, ci, ccr, result, ccr_out, er[7:0], ec[7:0]);
        end
        checks++;
        if (wr_en !== 1'(ew)) begin
            failures++;
            $display("FAIL R13 op=%0d: got wr_en=%0b, expected %0d", op, wr_en, ew);
        end
    endtask

    initial begin
        // idle inputs: add of zeros gives zero with only Z set (R2)
        run_vec(0, 0, 0, 0, 0, "R2 idle");
        // upper flag bits and half-carry pass for every code (R1)
        for (int op = 0; op < 32; op++) begin
            run_vec(op, 8'h3C, 8'hA5, 1, 8'hD0, "R1");
            run_vec(op, 8'h3C, 8'hA5, 0, 8'h2F, "R1");
        end
        // directed edges
        run_vec(13, 8'h7F, 0, 0, 8'h01, "R8 inc 7F");
        run_vec(14, 8'h80, 0, 0, 8'h00, "R8 dec 80");
        run_vec(12, 8'h80, 0, 0, 8'h00, "R7 neg 80");
        run_vec(12, 8'h00, 0, 0, 8'h01, "R7 neg 0");
        run_vec(10, 8'h55, 0, 1, 8'h0B, "R5");
        run_vec(21, 8'h9A, 0, 0, 8'h00, "R12 9A");
        run_vec(21, 8'h0F, 0, 0, 8'h20, "R12 H");
        // exhaustive add-with-carry and subtract-with-borrow (R2, R3)
        for (int ci = 0; ci < 2; ci++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++) begin
                    run_vec(1, a, b, ci, (a * 7 + b * 13) & 255, "R2");
                    run_vec(3, a, b, ci, (a * 11 + b * 5) & 255, "R3");
                end
        // every other code over all first operands and spread second operands
        for (int op = 0; op < 32; op++) begin
            if (op == 1 || op == 3) continue;
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += (op < 22) ? 5 : 51)
                    run_vec(op, a, b, (a ^ b) & 1, (a * 7 + b * 13 + op) & 255, tag_of(op));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule